// File: doc/BRIEF.md
# Dual-Role Toggle and CC Sampling Timer

This block paces an unattached dual-role port. On a 1 ms tick it alternates the advertised role between source (downstream-facing) and sink (upstream-facing) over a fixed toggle period. A two-bit duty code picks what share of that period is spent as source. It also emits a one-cycle strobe that tells the analog front end when to sample the CC lines.

Sampling has two modes. In the first, strobes come on a programmable interval with no pause. In the second, one strobe comes on the tick just before each role change. When the port reports an attachment, toggling and sampling freeze. When the attachment goes away, the timer restarts at the beginning of a source phase.

Configuration inputs are captured into a shadow register only at a period boundary, or while the timer is idle. A change made partway through a period therefore applies from the next period on.

Top module: `drp_toggle_timer`

## Requirements
- R1: Synchronous active-high reset. After reset, role_src is 1 (source) and sample_stb is 0. If enable stays high through reset, the first period uses duty code 00 and rate code 01 in continuous mode, whatever the inputs are.
- R2: The source phase lasts floor(PERIOD*pct/100) ticks from the start of each period, and the rest of the period is sink. The duty code sets pct: 00 → 30, 01 → 10, 10 → 50, 11 → 60.
- R3: A period is PERIOD ticks long (default 80). role_src returns to 1 on the tick that closes the period. role_src = 1 means source and 0 means sink. Outputs change on the clock edge that samples the tick.
- R4: With sample_mode = 0, sample_stb pulses for one cycle on every Nth tick, on the edge that samples that tick. The rate code sets N: 00 → 1, 01 → 2, 10 → 8, 11 → 16. It is 0 in every other cycle.
- R5: With sample_mode = 1, sample_stb pulses only on the tick that immediately precedes a role change, from source to sink or from sink to source.
- R6: While attached is 1 (with enable high), role_src holds its value and sample_stb stays 0.
- R7: When attached falls, role_src becomes 1 within one cycle. Counting restarts at the start of the source phase, and the sample interval restarts too.
- R8: Changes to duty_code, rate_code or sample_mode made during a running period take effect only from the next period.
- R9: While enable is 0, role_src is 1 and sample_stb is 0. The timer restarts from the start of a period when enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| enable | input | 1 | Enables autonomous toggling |
| attached | input | 1 | Port attached; freezes the timer |
| duty_code | input | 2 | Source share code |
| rate_code | input | 2 | Continuous sampling interval code |
| sample_mode | input | 1 | 0 = continuous sampling, 1 = sample just before toggles |
| role_src | output | 1 | 1 = advertising source, 0 = sink |
| sample_stb | output | 1 | One-cycle CC sample request |

## Verification
The bench first holds non-default inputs through reset. A design that loaded them at once would show the wrong source length and strobe spacing in the first period. It then changes the configuration in the middle of a period. A design that failed to shadow the inputs would shorten or lengthen the phase in progress. Every duty code and every rate code is run, including rate 00, where a strobe comes on every tick, so an off-by-one interval counter would show up as doubled or missing pulses. The pre-toggle mode is checked on both edges of the phase: a strobe one tick late or one tick early would fail. Attach and disable windows are placed mid-phase, so a design that kept counting or failed to restart as source on release would come out of phase with the bench.

// File: rtl/drp_timer_pkg.sv
package drp_timer_pkg;

  typedef struct packed {
    logic [1:0] duty;
    logic [1:0] rate;
    logic       mode;
  } drp_cfg_t;

  localparam logic [1:0] DUTY_RST = 2'b00;
  localparam logic [1:0] RATE_RST = 2'b01;
  localparam int unsigned MAX_IVL = 16;

  // share of the period spent as source, in percent
  function automatic int unsigned duty_pct(input logic [1:0] code);
    case (code)
      2'b00:   return 30;
      2'b01:   return 10;
      2'b10:   return 50;
      default: return 60;
    endcase
  endfunction

  // continuous sampling interval in ticks
  function automatic int unsigned rate_ticks(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/drp_cfg_shadow.sv
module drp_cfg_shadow
  import drp_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] duty_in,
  input  logic [1:0] rate_in,
  input  logic       mode_in,
  output drp_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.duty <= DUTY_RST;
      cfg.rate <= RATE_RST;
      cfg.mode <= 1'b0;
    end else if (load) begin
      cfg.duty <= duty_in;
      cfg.rate <= rate_in;
      cfg.mode <= mode_in;
    end
  end

  // configuration only moves at a load point
  assert_cfg_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg));

endmodule

// File: rtl/drp_phase_ctr.sv
module drp_phase_ctr
  import drp_timer_pkg::*;
#(
  parameter int unsigned PERIOD = 80,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          attached,
  input  logic          tick,
  input  logic [1:0]    duty,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] src_len,
  output logic          wrap,
  output logic          role_src
);

  logic          run;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] len_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign len_tab[g] = CW'(PERIOD * duty_pct(2'(g)) / 100);
  end

  assign src_len = len_tab[duty];
  assign run     = enable & ~attached;
  assign wrap    = run & tick & (cnt == CW'(PERIOD - 1));
  assign cnt_n   = wrap ? '0 : cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      role_src <= 1'b1;
    end else if (!enable) begin
      cnt      <= '0;
      role_src <= 1'b1;
    end else if (attached) begin
      cnt      <= '0;
    end else if (tick) begin
      cnt      <= cnt_n;
      role_src <= (cnt_n == '0) | (cnt_n < src_len);
    end else begin
      role_src <= cnt < src_len;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(PERIOD));

  assert_wrap_source_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> role_src);

  assert_attach_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && attached) |=> $stable(role_src));

  assert_release_source_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && $fell(attached)) |=> role_src);

  assert_disabled_source_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> role_src);

endmodule

// File: rtl/drp_sample_gen.sv
module drp_sample_gen
  import drp_timer_pkg::*;
#(
  parameter int unsigned PERIOD = 80,
  localparam int unsigned CW = $clog2(PERIOD),
  localparam int unsigned SW = $clog2(MAX_IVL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] src_len,
  input  logic [1:0]    rate,
  input  logic          mode,
  output logic          sample_stb
);

  logic [SW-1:0] scnt;
  logic [SW-1:0] ivl_m1 [4];
  logic          pre_toggle;

  for (genvar g = 0; g < 4; g++) begin : g_ivl
    assign ivl_m1[g] = SW'(rate_ticks(2'(g)) - 1);
  end

  // tick that moves cnt to the last count before a role change
  assign pre_toggle = (cnt == src_len - CW'(2)) | (cnt == CW'(PERIOD - 2));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      scnt       <= '0;
      sample_stb <= 1'b0;
    end else if (tick) begin
      if (mode) begin
        scnt       <= '0;
        sample_stb <= pre_toggle;
      end else if (scnt >= ivl_m1[rate]) begin
        scnt       <= '0;
        sample_stb <= 1'b1;
      end else begin
        scnt       <= scnt + SW'(1);
        sample_stb <= 1'b0;
      end
    end else begin
      sample_stb <= 1'b0;
    end
  end

  assert_stb_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(tick));

  assert_stb_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sample_stb);

endmodule

// File: rtl/drp_toggle_timer.sv
module drp_toggle_timer
  import drp_timer_pkg::*;
#(
  parameter int unsigned PERIOD = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1ms,
  input  logic       enable,
  input  logic       attached,
  input  logic [1:0] duty_code,
  input  logic [1:0] rate_code,
  input  logic       sample_mode,
  output logic       role_src,
  output logic       sample_stb
);

  localparam int unsigned CW = $clog2(PERIOD);

  drp_cfg_t      cfg;
  logic [CW-1:0] cnt;
  logic [CW-1:0] src_len;
  logic          wrap;
  logic          run;
  logic          load;

  assign run  = enable & ~attached;
  assign load = ~enable | attached | wrap;

  drp_cfg_shadow u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .duty_in (duty_code),
    .rate_in (rate_code),
    .mode_in (sample_mode),
    .cfg     (cfg)
  );

  drp_phase_ctr #(.PERIOD(PERIOD)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .attached (attached),
    .tick     (tick_1ms),
    .duty     (cfg.duty),
    .cnt      (cnt),
    .src_len  (src_len),
    .wrap     (wrap),
    .role_src (role_src)
  );

  drp_sample_gen #(.PERIOD(PERIOD)) u_sample (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .tick       (tick_1ms),
    .cnt        (cnt),
    .src_len    (src_len),
    .rate       (cfg.rate),
    .mode       (cfg.mode),
    .sample_stb (sample_stb)
  );

  assert_no_stb_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sample_stb);

  assert_no_stb_attached_R6: assert property (@(posedge clk) disable iff (rst)
    attached |=> !sample_stb);

endmodule

// File: tb/drp_toggle_timer_bench.sv
module drp_toggle_timer_bench;

  localparam int P = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic en = 1'b1;
  logic att = 1'b0;
  logic [1:0] duty = 2'b11;
  logic [1:0] rate = 2'b11;
  logic mode = 1'b0;
  logic role_src, sample_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  int m_cnt = 0, m_scnt = 0;
  logic [1:0] m_duty = 2'b00, m_rate = 2'b01;
  logic m_mode = 1'b0, m_role = 1'b1;

  always #4 clk = ~clk;

  drp_toggle_timer #(.PERIOD(P)) u_drp_toggle_timer (
    .clk(clk), .rst(rst), .tick_1ms(tick), .enable(en), .attached(att),
    .duty_code(duty), .rate_code(rate), .sample_mode(mode),
    .role_src(role_src), .sample_stb(sample_stb)
  );

  function automatic int pct(input logic [1:0] c);
    case (c) 2'b00: return 30; 2'b01: return 10; 2'b10: return 50; default: return 60; endcase
  endfunction

  function automatic int ivl(input logic [1:0] c);
    case (c) 2'b00: return 1; 2'b01: return 2; 2'b10: return 8; default: return 16; endcase
  endfunction

  function automatic int slen(input logic [1:0] c);
    return P * pct(c) / 100;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic load_cfg();
    m_duty = duty; m_rate = rate; m_mode = mode;
  endtask

  // driver: advance the model by one tick, queue the expectation, pulse tick
  task automatic tick_once(input string tag);
    bit stb;
    if (!en) begin
      m_cnt = 0; m_scnt = 0; load_cfg(); m_role = 1'b1; stb = 1'b0;
    end else if (att) begin
      m_cnt = 0; m_scnt = 0; load_cfg(); stb = 1'b0;
    end else begin
      if (m_mode) begin
        stb = (m_cnt == slen(m_duty) - 2) || (m_cnt == P - 2);
        m_scnt = 0;
      end else if (m_scnt >= ivl(m_rate) - 1) begin
        stb = 1'b1; m_scnt = 0;
      end else begin
        stb = 1'b0; m_scnt++;
      end
      if (m_cnt == P - 1) begin
        m_cnt = 0; load_cfg();
      end else m_cnt++;
      m_role = (m_cnt == 0) || (m_cnt < slen(m_duty));
    end
    exp_q.push_back({m_role, stb});
    tag_q.push_back(tag);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick_once(tag);
  endtask

  // monitor: compare outputs after each tick edge, strobe must be quiet otherwise
  always @(posedge clk) begin
    logic t;
    logic [1:0] e;
    string tg;
    if (!rst && mon_on) begin
      t = tick;
      @(negedge clk);
      if (t) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "queue underflow", 0, 1);
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(role_src === e[1], {tg, " role_src"}, int'(role_src), int'(e[1]));
          check(sample_stb === e[0], {tg, " sample_stb"}, int'(sample_stb), int'(e[0]));
        end
      end else begin
        check(sample_stb === 1'b0, "R4 strobe between ticks", int'(sample_stb), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(role_src === 1'b1, "R1 reset role", int'(role_src), 1);
    check(sample_stb === 1'b0, "R1 reset strobe", int'(sample_stb), 0);
    mon_on = 1'b1;
    run(80, "R1");                      // defaults: 30 %, every 2 ticks
    run(40, "R2");                      // 60 %, every 16 ticks
    duty = 2'b01; rate = 2'b00;
    run(40, "R8");                      // mid-period change must not apply
    run(20, "R3");                      // 10 %, every tick
    duty = 2'b10; rate = 2'b10;
    run(60, "R3");
    run(40, "R2");                      // 50 %, every 8 ticks
    mode = 1'b1; duty = 2'b00;
    run(40, "R4");
    run(80, "R5");                      // pre-toggle sampling, 30 %
    duty = 2'b11;
    run(80, "R5");
    mode = 1'b0; rate = 2'b01;
    run(80, "R5");                      // pre-toggle sampling, 60 %
    run(30, "R2");
    att = 1'b1;
    run(10, "R6");
    att = 1'b0;
    repeat (2) @(negedge clk);
    check(role_src === 1'b1, "R7 release role", int'(role_src), 1);
    run(100, "R7");
    run(10, "R2");
    en = 1'b0;
    run(5, "R9");
    check(role_src === 1'b1, "R9 disabled role", int'(role_src), 1);
    en = 1'b1;
    run(80, "R9");
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    check(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule